// File: doc/BRIEF.md
# Bit-Sliced Small ALU

This block is a purely combinational arithmetic logic unit assembled from a row of identical one-bit slices. Each slice works out the bitwise XOR, AND and OR of its two operand bits. It also runs a full-adder stage. The adder stage takes its carry from the slice below and passes a carry to the slice above. A per-bit selector at the end of every slice picks one of those candidates according to a 3-bit operation code.

The operand width is a parameter with a default of 2. Bit 0 is the least significant position. The carry input feeds the lowest slice and ripples through every slice. The final carry is brought out so that an outside status register can capture it.

Four of the eight operation codes carry a function. The other four are held back for later functions, and they give a fixed all-zero output so the block never presents an undefined value. The block has no clock and no reset. Its outputs settle from its inputs alone.

Top module: `alu_sliced`

## Requirements
- R1: With op_sel = 3'b000 the result equals opnd_a XOR opnd_b, bit by bit.
- R2: With op_sel = 3'b001 the result equals opnd_a AND opnd_b, bit by bit.
- R3: With op_sel = 3'b010 the result equals opnd_a OR opnd_b, bit by bit.
- R4: With op_sel = 3'b011 the concatenation {carry_out, result} equals opnd_a + opnd_b + carry_in as a WIDTH+1 bit unsigned sum.
- R5: With op_sel in 3'b100 to 3'b111 both result and carry_out are all zeros, whatever the operands and carry input.
- R6: With op_sel in 3'b000 to 3'b010 carry_out is 0 and carry_in has no effect on result.
- R7: Bit 0 is the least significant bit and the carry ripples through all WIDTH slices: with opnd_a all ones, opnd_b zero, carry_in 1 and op_sel = 3'b011, result is zero and carry_out is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand, bit 0 least significant |
| opnd_b | input | WIDTH | Second operand, bit 0 least significant |
| carry_in | input | 1 | Carry into the lowest slice |
| op_sel | input | 3 | Operation code: 000 XOR, 001 AND, 010 OR, 011 add, 100-111 reserved |
| result | output | WIDTH | Selected function of the operands |
| carry_out | output | 1 | Carry from the highest slice during add, else 0 |

## Verification
The assertions take for granted that every input carries a settled 0 or 1. They evaluate whenever the combinational logic re-evaluates, so an X on an operand or on the opcode would make the arithmetic and zero checks meaningless. The bench drives only known values. It changes inputs on one clock edge and samples the outputs on the opposite edge, so each assertion and each comparison sees the network after it has settled. The stimulus runs through every combination of operands, carry input and opcode, including all four reserved codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int unsigned OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_XOR  = 3'b000,
      OP_AND  = 3'b001,
      OP_OR   = 3'b010,
      OP_ADD  = 3'b011,
      OP_RSV4 = 3'b100,
      OP_RSV5 = 3'b101,
      OP_RSV6 = 3'b110,
      OP_RSV7 = 3'b111
   } alu_op_e;

   // Codes with the top bit set are held back for future functions.
   function automatic logic op_is_reserved(input logic [OP_W-1:0] code);
      return code[OP_W-1];
   endfunction

   function automatic logic op_is_logic(input logic [OP_W-1:0] code);
      return !code[OP_W-1] && (code != OP_ADD);
   endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
   input  logic bit_a,
   input  logic bit_b,
   input  logic c_in,
   output logic f_xor,
   output logic f_and,
   output logic f_or,
   output logic f_sum,
   output logic c_out
);

   logic half_sum;

   always_comb begin
      f_xor    = bit_a ^ bit_b;
      f_and    = bit_a & bit_b;
      f_or     = bit_a | bit_b;
      half_sum = bit_a ^ bit_b;
      f_sum    = half_sum ^ c_in;
      c_out    = f_and | (half_sum & c_in);
   end

   // R4: a carry leaves the slice exactly when two or more of its inputs are set
   always_comb begin
      a_r4_slice_majority: assert (c_out == ($countones({bit_a, bit_b, c_in}) >= 2))
         else $error("slice carry disagrees with input count");
      a_r4_slice_parity: assert (f_sum == $countones({bit_a, bit_b, c_in}) % 2)
         else $error("slice sum disagrees with input parity");
   end

endmodule

// File: rtl/alu_bit_select.sv
module alu_bit_select
   import alu_pkg::*;
#(
   parameter logic RESERVED_FILL = 1'b0
) (
   input  logic [OP_W-1:0] sel,
   input  logic            f_xor,
   input  logic            f_and,
   input  logic            f_or,
   input  logic            f_sum,
   output logic            y
);

   always_comb begin
      unique case (sel)
         OP_XOR:  y = f_xor;
         OP_AND:  y = f_and;
         OP_OR:   y = f_or;
         OP_ADD:  y = f_sum;
         default: y = RESERVED_FILL;
      endcase
   end

   // R5: reserved codes never pass an operand-derived bit
   always_comb begin
      a_r5_select_fill: assert (!op_is_reserved(sel) || (y == RESERVED_FILL))
         else $error("reserved code produced a non-fill bit");
   end

endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH = 2
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   input  logic [OP_W-1:0]  op_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   localparam int unsigned CHAIN_LEN = WIDTH + 1;

   initial begin
      a_width_legal: assert (WIDTH >= 1 && WIDTH <= 64)
         else $error("WIDTH must lie in 1..64");
   end

   logic [CHAIN_LEN-1:0] chain;
   logic [WIDTH-1:0]     v_xor, v_and, v_or, v_sum;

   assign chain[0] = carry_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_bit_slice u_slice (
         .bit_a (opnd_a[i]),
         .bit_b (opnd_b[i]),
         .c_in  (chain[i]),
         .f_xor (v_xor[i]),
         .f_and (v_and[i]),
         .f_or  (v_or[i]),
         .f_sum (v_sum[i]),
         .c_out (chain[i+1])
      );

      alu_bit_select #(.RESERVED_FILL(1'b0)) u_sel (
         .sel   (op_sel),
         .f_xor (v_xor[i]),
         .f_and (v_and[i]),
         .f_or  (v_or[i]),
         .f_sum (v_sum[i]),
         .y     (result[i])
      );
   end

   assign carry_out = (op_sel == OP_ADD) ? chain[WIDTH] : 1'b0;

   always_comb begin
      // R4: the rippled chain forms the arithmetic sum
      a_r4_add_total: assert ((op_sel != OP_ADD) ||
         ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b} + {{WIDTH{1'b0}}, carry_in})))
         else $error("add result mismatch");
      // R5: reserved codes give an all-zero output
      a_r5_reserved_zero: assert (!op_is_reserved(op_sel) || ({carry_out, result} == '0))
         else $error("reserved code gave non-zero output");
      // R6: logic functions never report a carry
      a_r6_logic_no_carry: assert (!op_is_logic(op_sel) || !carry_out)
         else $error("logic op produced a carry");
      // R2/R3: an AND bit can never be set where the OR bit is clear
      a_r3_and_within_or: assert ((v_and & ~v_or) == '0)
         else $error("AND set outside OR");
   end

endmodule

// File: tb/alu_sliced_bench.sv
module alu_sliced_bench;

   localparam int unsigned WIDTH = 2;
   localparam time CLK_PERIOD = 10ns;
   localparam int unsigned WATCHDOG_CYCLES = 5000;

   logic             clk = 1'b0;
   logic [WIDTH-1:0] opnd_a = '0;
   logic [WIDTH-1:0] opnd_b = '0;
   logic             carry_in = 1'b0;
   logic [2:0]       op_sel = 3'b000;
   logic [WIDTH-1:0] result;
   logic             carry_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_sliced #(.WIDTH(WIDTH)) u_alu_sliced (
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .carry_in  (carry_in),
      .op_sel    (op_sel),
      .result    (result),
      .carry_out (carry_out)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s a=%0d b=%0d cin=%0d op=%0d actual=%0d expected=%0d",
                  req, opnd_a, opnd_b, carry_in, op_sel, got, exp);
      end
   endtask

   task automatic apply(input int a, input int b, input int c, input int op);
      @(posedge clk);
      opnd_a   = WIDTH'(a);
      opnd_b   = WIDTH'(b);
      carry_in = c[0];
      op_sel   = 3'(op);
      @(negedge clk);
   endtask

   initial begin
      int full;
      int ea, eb;
      int ref_res, ref_co;
      string req;
      full = 1 << WIDTH;

      // Idle state with all inputs zero: XOR of zeros, no carry
      @(negedge clk);
      check("R1", int'(result), 0);
      check("R6", int'(carry_out), 0);

      // Exhaustive sweep against a behavioural model
      for (int op = 0; op < 8; op++) begin
         for (int a = 0; a < full; a++) begin
            for (int b = 0; b < full; b++) begin
               for (int c = 0; c < 2; c++) begin
                  apply(a, b, c, op);
                  ea = a; eb = b;
                  case (op)
                     0: begin ref_res = ea ^ eb; ref_co = 0; req = "R1"; end
                     1: begin ref_res = ea & eb; ref_co = 0; req = "R2"; end
                     2: begin ref_res = ea | eb; ref_co = 0; req = "R3"; end
                     3: begin
                        ref_res = (ea + eb + c) % full;
                        ref_co  = (ea + eb + c) / full;
                        req = "R4";
                     end
                     default: begin ref_res = 0; ref_co = 0; req = "R5"; end
                  endcase
                  check(req, int'(result), ref_res);
                  if (op < 3) check("R6", int'(carry_out), ref_co);
                  else        check(req, int'(carry_out), ref_co);
               end
            end
         end
      end

      // R6: flipping carry_in leaves logic results unchanged
      for (int op = 0; op < 3; op++) begin
         int first;
         apply(full - 1, 1, 0, op);
         first = int'(result);
         apply(full - 1, 1, 1, op);
         check("R6", int'(result), first);
      end

      // R7: carry ripples through every slice and bit 0 is the low bit
      apply(full - 1, 0, 1, 3);
      check("R7", int'(result), 0);
      check("R7", int'(carry_out), 1);
      apply(1, 0, 0, 3);
      check("R7", int'(result[0]), 1);
      apply(0, 0, 1, 3);
      check("R7", int'(result), 1);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule